// File: doc/BRIEF.md
# Quad-SPI Flash Instruction Fetcher

This block stands in for a parallel instruction bus. It reads 16-bit instruction words from an external serial NOR flash. When reset is released it plays a fixed start-up script over single-line SPI. The script wakes the flash, sets its quad-enable bit and opens a quad fast-read with a continuous-read mode byte. After that the flash link stays open, and the processor's fetches are served four bits per serial clock.

The processor pulses `fetch_req` with a word address. If that address follows the previous fetch, the block only clocks out the next four nibbles. Any other address ends the transfer and opens a new one at byte address 2 × word address. Because continuous-read mode is already active, the new transfer carries no command byte. Each finished word appears on `insn_word` together with a one-cycle `insn_valid` pulse. One cycle earlier, `fetch_strobe` marks the end of the fetch.

The serial clock runs at half the system clock and idles low. The block drives each bit or nibble while SCK is low. Read data must be stable while SCK is high, and the block captures it at the end of that high phase. The flash changes its data after the falling edge.

Top module: `qsf_fetch`

## Requirements
- R1: While `rst_n` is low, `flash_cs_n` is 1, `flash_sck` is 0, `flash_doe` is 4'b0000 and `insn_valid` is 0.
- R2: The start-up script sends FFh, ABh, 06h, 01h, 02h, 02h, EBh in that order, MSB first on D[0] only, with `flash_doe` = 4'b0001 and the bit stable across each SCK rising edge.
- R3: The start-up script is framed into five chip-select transactions: {FFh}, {ABh}, {06h}, {01h 02h 02h} and {EBh …}, with CS held high for at least `CS_HIGH_CLKS` clocks between them.
- R4: After EBh, in the same transaction, seven bytes go out on D[3:0] with `flash_doe` = 4'b1111, high nibble first: a 3-byte big-endian byte address, then three 00h bytes, then A5h. The start-up read uses address 0.
- R5: After A5h, `flash_doe` is 4'b0000 for `DUMMY_SCK` SCK cycles and for the whole data return.
- R6: A fetch reads four nibbles, high first. `insn_word` = {byte(2w), byte(2w+1)} for word address w, and `insn_valid` is high for exactly one cycle.
- R7: `fetch_strobe` is high for exactly one cycle per fetch, in the cycle just before `insn_valid`.
- R8: A request for the word that follows the previous fetch is served inside the open transaction, with no new CS assertion.
- R9: A request for any other word raises CS. It then starts a new transaction that holds only the R4 seven-byte header at byte address 2 × w, with no command byte, followed by the R5 dummy phase.
- R10: A request made while the start-up script is running is held and served once the script is complete.
- R11: Asserting `rst_n` low at any point, including mid-fetch, restarts the full start-up script from FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | One-cycle fetch request |
| fetch_addr | input | AW | Word address of the request |
| insn_word | output | 16 | Last fetched instruction |
| insn_valid | output | 1 | One-cycle pulse: `insn_word` is new |
| fetch_strobe | output | 1 | End-of-fetch strobe, one cycle before `insn_valid` |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_dout | output | 4 | Data driven toward the flash |
| flash_doe | output | 4 | Per-line output enable for `flash_dout` |
| flash_din | input | 4 | Data returned by the flash |

## Verification
The assertions assume the processor keeps at most one request outstanding. They also assume the flash holds `flash_din` steady while SCK is high and only changes it after a falling edge. The bench issues a new request only after the previous `insn_valid` has been seen. The exception is the deliberate reset during a fetch. The bench's flash responder updates its data lines only on SCK falling edges. The responder decodes what the block sends from the lines alone: command bytes, the quad header and output-enable states. It returns data computed from byte addresses. Its continuous-read state is cleared together with each deliberate reset of the block.

// File: rtl/qsf_pkg.sv
package qsf_pkg;
    typedef enum logic [2:0] {
        ST_GAP   = 3'd0,
        ST_CMD   = 3'd1,
        ST_QOUT  = 3'd2,
        ST_DUMMY = 3'd3,
        ST_IDLE  = 3'd4,
        ST_DATA  = 3'd5
    } qsf_state_e;

    localparam logic [2:0] IDX_DONE   = 3'd7;  // script finished marker
    localparam logic [2:0] IDX_QREAD  = 3'd6;  // quad read command slot
    localparam logic [2:0] QIDX_MODE  = 3'd6;  // last header byte
    localparam logic [7:0] MODE_BYTE  = 8'hA5;
endpackage

// File: rtl/qsf_cmd_rom.sv
module qsf_cmd_rom (
    output logic [7:0][7:0] cmd_bytes,
    output logic [7:0]      cmd_last
);
    // slot 0 first; slot 7 unused
    assign cmd_bytes = {8'h00, 8'hEB, 8'h02, 8'h02, 8'h01, 8'h06, 8'hAB, 8'hFF};
    // slots that close their chip-select frame
    assign cmd_last  = 8'b0010_0111;
endmodule

// File: rtl/qsf_quad_seq.sv
module qsf_quad_seq
    import qsf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]   word_addr,
    output logic [7:0][7:0] hdr
);
    localparam int BAW = 24;
    logic [BAW-1:0] byte_addr;
    assign byte_addr = BAW'({word_addr, 1'b0});

    for (genvar i = 0; i < 3; i++) begin : g_addr
        assign hdr[i] = byte_addr[BAW-1-8*i -: 8];
    end
    for (genvar j = 3; j < 6; j++) begin : g_pad
        assign hdr[j] = 8'h00;
    end
    assign hdr[6] = MODE_BYTE;
    assign hdr[7] = 8'h00;
endmodule

// File: rtl/qsf_fetch.sv
module qsf_fetch
    import qsf_pkg::*;
#(
    parameter int AW           = 16,
    parameter int DUMMY_SCK    = 4,
    parameter int CS_HIGH_CLKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    output logic [15:0]   insn_word,
    output logic          insn_valid,
    output logic          fetch_strobe,
    output logic          flash_cs_n,
    output logic          flash_sck,
    output logic [3:0]    flash_dout,
    output logic [3:0]    flash_doe,
    input  logic [3:0]    flash_din
);
    localparam int GW = $clog2(CS_HIGH_CLKS + 1);
    localparam int DW = $clog2(DUMMY_SCK + 1);

    typedef struct packed {
        qsf_state_e    st;
        logic          cs_n;
        logic          sck;
        logic [3:0]    dout;
        logic [3:0]    doe;
        logic [2:0]    idx;
        logic [2:0]    qidx;
        logic [2:0]    bitcnt;
        logic [7:0]    sh;
        logic [GW-1:0] gcnt;
        logic [DW-1:0] dcnt;
        logic [15:0]   word;
        logic [15:0]   insn;
        logic          valid;
        logic          fetch;
        logic          pend;
        logic [AW-1:0] paddr;
        logic [AW-1:0] naddr;
    } regs_t;

    regs_t q, d;

    logic [7:0][7:0] cmd_bytes;
    logic [7:0]      cmd_last;
    logic [7:0][7:0] hdr;

    qsf_cmd_rom u_rom (.cmd_bytes(cmd_bytes), .cmd_last(cmd_last));
    qsf_quad_seq #(.AW(AW)) u_hdr (.word_addr(q.naddr), .hdr(hdr));

    logic [2:0]  idx_nx, qidx_nx;
    logic [15:0] word_nx;
    logic [7:0]  sh_nx;
    assign idx_nx  = q.idx + 3'd1;
    assign qidx_nx = q.qidx + 3'd1;
    assign word_nx = {q.word[11:0], flash_din};
    assign sh_nx   = {q.sh[6:0], 1'b0};

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.fetch = 1'b0;
        unique case (q.st)
            ST_GAP: begin
                d.cs_n = 1'b1;
                d.sck  = 1'b0;
                d.doe  = 4'b0000;
                d.dout = 4'b0000;
                if (q.gcnt == GW'(CS_HIGH_CLKS - 1)) begin
                    d.gcnt   = '0;
                    d.cs_n   = 1'b0;
                    d.bitcnt = '0;
                    if (q.idx != IDX_DONE) begin
                        d.st   = ST_CMD;
                        d.sh   = cmd_bytes[q.idx];
                        d.dout = {3'b000, cmd_bytes[q.idx][7]};
                        d.doe  = 4'b0001;
                    end else begin
                        d.st   = ST_QOUT;
                        d.qidx = '0;
                        d.dout = hdr[0][7:4];
                        d.doe  = 4'b1111;
                    end
                end else begin
                    d.gcnt = q.gcnt + GW'(1);
                end
            end
            ST_CMD: begin
                d.sck = ~q.sck;
                if (q.sck) begin
                    if (q.bitcnt == 3'd7) begin
                        d.bitcnt = '0;
                        if (q.idx == IDX_QREAD) begin
                            d.st   = ST_QOUT;
                            d.idx  = IDX_DONE;
                            d.qidx = '0;
                            d.dout = hdr[0][7:4];
                            d.doe  = 4'b1111;
                        end else if (cmd_last[q.idx]) begin
                            d.st   = ST_GAP;
                            d.cs_n = 1'b1;
                            d.doe  = 4'b0000;
                            d.dout = 4'b0000;
                            d.idx  = idx_nx;
                            d.gcnt = '0;
                        end else begin
                            d.idx  = idx_nx;
                            d.sh   = cmd_bytes[idx_nx];
                            d.dout = {3'b000, cmd_bytes[idx_nx][7]};
                        end
                    end else begin
                        d.bitcnt = q.bitcnt + 3'd1;
                        d.sh     = sh_nx;
                        d.dout   = {3'b000, sh_nx[7]};
                    end
                end
            end
            ST_QOUT: begin
                d.sck = ~q.sck;
                if (q.sck) begin
                    if (q.bitcnt == 3'd0) begin
                        d.dout   = hdr[q.qidx][3:0];
                        d.bitcnt = 3'd1;
                    end else if (q.qidx == QIDX_MODE) begin
                        d.st     = ST_DUMMY;
                        d.doe    = 4'b0000;
                        d.dout   = 4'b0000;
                        d.dcnt   = '0;
                        d.bitcnt = '0;
                    end else begin
                        d.qidx   = qidx_nx;
                        d.dout   = hdr[qidx_nx][7:4];
                        d.bitcnt = '0;
                    end
                end
            end
            ST_DUMMY: begin
                d.sck = ~q.sck;
                if (q.sck) begin
                    if (q.dcnt == DW'(DUMMY_SCK - 1)) d.st = ST_IDLE;
                    else                               d.dcnt = q.dcnt + DW'(1);
                end
            end
            ST_IDLE: begin
                d.sck = 1'b0;
                if (q.pend) begin
                    if (q.paddr == q.naddr) begin
                        d.st     = ST_DATA;
                        d.bitcnt = '0;
                        d.pend   = 1'b0;
                    end else begin
                        d.st    = ST_GAP;
                        d.cs_n  = 1'b1;
                        d.gcnt  = '0;
                        d.idx   = IDX_DONE;
                        d.naddr = q.paddr;
                    end
                end
            end
            ST_DATA: begin
                d.sck = ~q.sck;
                if (!q.sck) begin
                    d.fetch = (q.bitcnt == 3'd3);
                end else begin
                    d.word = word_nx;
                    if (q.bitcnt == 3'd3) begin
                        d.insn  = word_nx;
                        d.valid = 1'b1;
                        d.naddr = q.naddr + AW'(1);
                        d.st    = ST_IDLE;
                    end else begin
                        d.bitcnt = q.bitcnt + 3'd1;
                    end
                end
            end
            default: d.st = ST_GAP;
        endcase
        if (fetch_req) begin
            d.pend  = 1'b1;
            d.paddr = fetch_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_GAP;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign insn_word    = q.insn;
    assign insn_valid   = q.valid;
    assign fetch_strobe = q.fetch;
    assign flash_cs_n   = q.cs_n;
    assign flash_sck    = q.sck;
    assign flash_dout   = q.dout;
    assign flash_doe    = q.doe;

    // R2: only the single data line is driven while commands are shifted
    assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CMD) |-> (flash_doe == 4'b0001 && flash_dout[3:1] == 3'b000));

    // R3: SCK pulses and driven lines only inside a chip-select frame
    assert_sck_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_sck || flash_doe != 4'b0000) |-> !flash_cs_n);

    // R5: lines released while the flash may drive them
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DUMMY || q.st == ST_DATA) |-> (flash_doe == 4'b0000));

    // R6: a word pulse lasts one cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> !insn_valid);

    // R7: end-of-fetch strobe leads every word by one cycle
    assert_strobe_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> $past(fetch_strobe));

    // R8: a word completes only inside an open frame
    assert_stream_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_strobe |-> (!flash_cs_n && flash_sck));
endmodule

// File: tb/qsf_fetch_tb.sv
module qsf_fetch_tb;
    localparam int AW        = 16;
    localparam int DUMMY_SCK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [15:0]   insn_word;
    logic          insn_valid, fetch_strobe;
    logic          flash_cs_n, flash_sck;
    logic [3:0]    flash_dout, flash_doe;
    logic [3:0]    din_m = 4'h0;

    always #4 clk = ~clk;

    qsf_fetch #(.AW(AW), .DUMMY_SCK(DUMMY_SCK), .CS_HIGH_CLKS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .insn_word(insn_word), .insn_valid(insn_valid), .fetch_strobe(fetch_strobe),
        .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_dout(flash_dout),
        .flash_doe(flash_doe), .flash_din(din_m)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input int b);
        return 8'((b * 37 + 11) ^ (b >> 8));
    endfunction
    function automatic logic [15:0] mem_word(input int w);
        return {mem_byte(2 * w), mem_byte(2 * w + 1)};
    endfunction

    // ---------------- flash responder ----------------
    int          rises = 0, qstart = 0, ntx = 0, nlog = 0, nquad = 0, nbyte_tx = 0;
    bit          quad_m = 0, cont_m = 0, doe_bad = 0;
    logic [7:0]  sh_m = 8'h00, qsh = 8'h00;
    logic [7:0]  logb [64];
    int          txb [16];
    logic [7:0]  qb [7];
    logic [23:0] rx_addr = 24'h0;

    always @(negedge flash_cs_n) begin
        rises    = 0;
        quad_m   = cont_m;
        qstart   = 0;
        nbyte_tx = 0;
        ntx++;
    end

    always @(posedge flash_cs_n) begin
        if (ntx > 0 && ntx <= 16) txb[ntx-1] = nbyte_tx;
    end

    always @(posedge flash_sck) begin
        if (!flash_cs_n) begin
            rises++;
            if (!quad_m) begin
                if (flash_doe != 4'b0001) doe_bad = 1;
                sh_m = {sh_m[6:0], flash_dout[0]};
                if (rises % 8 == 0) begin
                    if (nlog < 64) logb[nlog] = sh_m;
                    nlog++;
                    nbyte_tx++;
                    if (sh_m == 8'hEB) begin
                        quad_m = 1;
                        qstart = rises;
                    end
                end
            end else begin
                int k;
                k = rises - qstart - 1;
                if (k < 14) begin
                    if (flash_doe != 4'b1111) doe_bad = 1;
                    qsh = {qsh[3:0], flash_dout};
                    if (k % 2 == 1) qb[k/2] = qsh;
                    if (k == 13) begin
                        rx_addr = {qb[0], qb[1], qb[2]};
                        cont_m  = (qb[6] == 8'hA5);
                        nquad++;
                    end
                end else if (flash_doe != 4'b0000) begin
                    doe_bad = 1;
                end
            end
        end
    end

    always @(negedge flash_sck) begin
        if (!flash_cs_n && quad_m && rises >= qstart + 14 + DUMMY_SCK) begin
            int k;
            logic [7:0] b;
            k = rises - qstart - 14 - DUMMY_SCK;
            b = mem_byte(int'(rx_addr) + k / 2);
            din_m = (k % 2 == 0) ? b[7:4] : b[3:0];
        end
    end

    task automatic model_clear();
        cont_m = 0; quad_m = 0; nlog = 0; ntx = 0; nquad = 0; doe_bad = 0;
        for (int i = 0; i < 16; i++) txb[i] = 0;
    endtask

    // ---------------- fetch helper ----------------
    task automatic do_fetch(input int addr, input string req, output logic [15:0] got_word);
        int nstrobe;
        bit fprev, seen, lead_ok;
        nstrobe = 0; fprev = 0; seen = 0; lead_ok = 0;
        got_word = 16'hxxxx;
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = AW'(addr);
        @(negedge clk);
        fetch_req  = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (insn_valid) begin
                seen = 1; lead_ok = fprev; got_word = insn_word;
                break;
            end
            fprev = fetch_strobe;
            if (fetch_strobe) nstrobe++;
            @(negedge clk);
        end
        chk(seen, {req, " R6 valid seen"}, 32'(seen), 32'd1);
        chk(got_word == mem_word(addr), {req, " R6 word"}, 32'(got_word), 32'(mem_word(addr)));
        chk(lead_ok && nstrobe == 1, {req, " R7 strobe lead"}, 32'(nstrobe), 32'd1);
        @(negedge clk);
        chk(!insn_valid, {req, " R6 one-cycle pulse"}, 32'(insn_valid), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(flash_cs_n === 1'b1 && flash_sck === 1'b0, "R1 cs/sck in reset",
            32'({flash_cs_n, flash_sck}), 32'h2);
        chk(flash_doe === 4'b0000 && insn_valid === 1'b0, "R1 doe/valid in reset",
            32'({flash_doe, insn_valid}), 32'h0);
    endtask

    task automatic t_init();
        logic [7:0] exp_b [7] = '{8'hFF, 8'hAB, 8'h06, 8'h01, 8'h02, 8'h02, 8'hEB};
        int exp_tx [4] = '{1, 1, 1, 3};
        model_clear();
        rst_n = 1'b1;
        for (int i = 0; i < 3000 && nquad < 1; i++) @(negedge clk);
        chk(nlog == 7, "R2 script byte count", 32'(nlog), 32'd7);
        for (int i = 0; i < 7; i++)
            chk(logb[i] == exp_b[i], "R2 script byte", 32'(logb[i]), 32'(exp_b[i]));
        for (int i = 0; i < 4; i++)
            chk(txb[i] == exp_tx[i], "R3 frame length", 32'(txb[i]), 32'(exp_tx[i]));
        chk(ntx == 5, "R3 frame count", 32'(ntx), 32'd5);
        for (int i = 0; i < 6; i++)
            chk(qb[i] == 8'h00, "R4 header zero byte", 32'(qb[i]), 32'h0);
        chk(qb[6] == 8'hA5, "R4 mode byte", 32'(qb[6]), 32'hA5);
    endtask

    task automatic t_sequential();
        logic [15:0] w;
        int tx0;
        tx0 = ntx;
        for (int a = 0; a < 4; a++) do_fetch(a, "seq", w);
        chk(ntx == tx0, "R8 no new frame on sequential", 32'(ntx), 32'(tx0));
    endtask

    task automatic t_jump();
        logic [15:0] w;
        int tx0, log0;
        tx0 = ntx; log0 = nlog;
        do_fetch(16'h0040, "jump fwd", w);
        chk(ntx == tx0 + 1, "R9 new frame on jump", 32'(ntx), 32'(tx0 + 1));
        chk(rx_addr == 24'h80, "R9 byte address", 32'(rx_addr), 32'h80);
        chk(nlog == log0, "R9 no command byte", 32'(nlog), 32'(log0));
        do_fetch(16'h0041, "after jump", w);
        chk(ntx == tx0 + 1, "R8 sequential after jump", 32'(ntx), 32'(tx0 + 1));
        do_fetch(5, "jump back", w);
        chk(rx_addr == 24'hA, "R9 backward byte address", 32'(rx_addr), 32'hA);
        chk(doe_bad == 0, "R5 enables released in dummy/data", 32'(doe_bad), 32'd0);
    endtask

    task automatic t_restart_early_req();
        logic [15:0] w;
        bit seen;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 16'h0100;
        @(negedge clk);
        fetch_req = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
        // R10: request issued while the script runs
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 16'd3;
        @(negedge clk);
        fetch_req = 1'b0;
        seen = 0; w = 16'h0;
        for (int i = 0; i < 5000; i++) begin
            if (insn_valid) begin seen = 1; w = insn_word; break; end
            @(negedge clk);
        end
        chk(seen && w == mem_word(3), "R10 held request served", 32'(w), 32'(mem_word(3)));
        chk(nlog == 7 && logb[0] == 8'hFF, "R11 script replayed", 32'(logb[0]), 32'hFF);
        chk(rx_addr == 24'h6, "R10 re-addressed after script", 32'(rx_addr), 32'h6);
    endtask

    initial begin
        t_reset();
        t_init();
        t_sequential();
        t_jump();
        t_restart_early_req();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule